// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block works out the column address for every beat of a synchronous DRAM read or write burst. A controller pulses `start` together with the first column, a 3-bit length code and a wrap-order bit. Starting on the next clock, the block presents one column per cycle on `col`, with `beat_valid` high. On the final beat of a fixed-length burst it also raises `last_beat`.

Fixed-length bursts stay inside the aligned block of N columns that holds the start column. In sequential order the low bits count upward and wrap within that block. In interleaved order each beat's low bits are the start column's low bits XOR the beat number. The full-page length runs sequentially through all columns and wraps from the top column to the bottom one. It never ends by itself.

Either a stop strobe or a new `start` ends a burst early, on any cycle. The outputs are status and take no acknowledgement. The block has no back-pressure: a beat is presented for exactly one cycle, whether or not the consumer uses it.

Top module: `sdram_col_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first `start`, `beat_valid` and `last_beat` are 0 and `col` is 0.
- R2: A `start` sampled at a rising edge makes `beat_valid` 1 and `col` equal to the sampled `start_col` from that edge onward. This holds whatever state the block was in before the edge.
- R3: With `wrap_ilv`=0 and length N of 2, 4 or 8, beat k shows `col` = (start_col & ~(N-1)) | ((start_col + k) mod N). The bits above log2(N) never change during the burst.
- R4: With `wrap_ilv`=1 and length N of 2, 4 or 8, beat k shows `col` = start_col XOR k, where k < N.
- R5: With `len_code`=111 and `wrap_ilv`=0 (full page), beat k shows `col` = (start_col + k) mod 256. The burst runs past 256 beats with `last_beat` held at 0, and continues until it is stopped or restarted.
- R6: A fixed-length burst of N beats raises `last_beat` only on beat N-1. `beat_valid` is 0 on the following cycle unless a new `start` was sampled.
- R7: A `stop` sampled at an edge while no `start` is present leaves `beat_valid` at 0 from that edge. The beat shown in the cycle in which `stop` was given is the final one. If `start` and `stop` are sampled together, `start` wins.
- R8: A `start` during a burst drops the old sequence. The new burst begins at beat 0 of its own start column, length and order.
- R9: `len_code` is decoded as 000=1, 001=2, 010=4, 011=8 and 111=full page. Codes 100, 101 and 110, and code 111 with `wrap_ilv`=1, give a single-beat burst with `last_beat` set on that beat.
- R10: A `start` may be given on every clock. Each one produces one beat showing its own column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst (and interrupt any current one) |
| stop | input | 1 | End the current burst |
| len_code | input | 3 | Burst length code |
| wrap_ilv | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| start_col | input | 8 | First column of the burst |
| col | output | 8 | Column for the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | This beat is the final one of a fixed-length burst |

## Verification
Bursts of every length are started from columns that sit in the middle of their aligned block. This separates a wrap inside the block from a carry into the upper bits, and separates XOR order from increment order. A full-page burst is run past 256 beats to check the wrap-around and that `last_beat` stays low. Stops, restarts in mid-burst, starts on every clock, a start and a stop given together, and the unsupported length codes each test one priority rule or decode rule.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;
  localparam int unsigned COL_W_DEF = 8;
  localparam int unsigned LEN_CODE_W = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;
endpackage

// File: rtl/col_len_decode.sv
module col_len_decode
  import col_seq_pkg::*;
#(
  parameter int unsigned COL_W = COL_W_DEF
) (
  input  logic [LEN_CODE_W-1:0] code,
  input  logic                  ilv,
  output logic [COL_W-1:0]      wrap_mask,
  output logic                  page
);
  always_comb begin
    wrap_mask = '0;
    page      = 1'b0;
    case (code)
      LEN_2:    wrap_mask = COL_W'(1);
      LEN_4:    wrap_mask = COL_W'(3);
      LEN_8:    wrap_mask = COL_W'(7);
      LEN_PAGE: begin
        if (!ilv) begin
          wrap_mask = '1;
          page      = 1'b1;
        end
      end
      default:  wrap_mask = '0;
    endcase
  end
endmodule

// File: rtl/col_addr_map.sv
module col_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;

  always_comb begin
    low_seq = (base + beat) & wrap_mask;
    low_ilv = (base ^ beat) & wrap_mask;
    addr    = (base & ~wrap_mask) | (ilv ? low_ilv : low_seq);
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import col_seq_pkg::*;
#(
  parameter int unsigned COL_W = COL_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  stop,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  wrap_ilv,
  input  logic [COL_W-1:0]      start_col,
  output logic [COL_W-1:0]      col,
  output logic                  beat_valid,
  output logic                  last_beat
);
  logic             run_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             page_q;
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic [COL_W-1:0] addr;
  logic             at_end;

  col_len_decode #(.COL_W(COL_W)) u_dec (
    .code      (len_code),
    .ilv       (wrap_ilv),
    .wrap_mask (dec_mask),
    .page      (dec_page)
  );

  col_addr_map #(.COL_W(COL_W)) u_map (
    .base      (base_q),
    .beat      (beat_q),
    .wrap_mask (mask_q),
    .ilv       (ilv_q),
    .addr      (addr)
  );

  assign at_end = run_q && !page_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      page_q <= 1'b0;
    end else if (start) begin
      run_q  <= 1'b1;
      base_q <= start_col;
      beat_q <= '0;
      mask_q <= dec_mask;
      ilv_q  <= wrap_ilv && !dec_page;
      page_q <= dec_page;
    end else if (stop || at_end) begin
      run_q  <= 1'b0;
    end else if (run_q) begin
      beat_q <= beat_q + COL_W'(1);
    end
  end

  assign col        = run_q ? addr : '0;
  assign beat_valid = run_q;
  assign last_beat  = at_end;
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             last_beat
);
  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col == $past(start_col)));
  // R6
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !beat_valid);
  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !beat_valid);
  // R6
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (col == '0 && !last_beat));
  // R5
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !stop) |=> beat_valid);
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .stop       (stop),
  .start_col  (start_col),
  .col        (col),
  .beat_valid (beat_valid),
  .last_beat  (last_beat)
);

// File: tb/sdram_col_seq_test.sv
module sdram_col_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic       stop = 0;
  logic [2:0] len_code = 0;
  logic       wrap_ilv = 0;
  logic [7:0] start_col = 0;
  logic [7:0] col;
  logic       beat_valid;
  logic       last_beat;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_col_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .len_code(len_code), .wrap_ilv(wrap_ilv), .start_col(start_col),
    .col(col), .beat_valid(beat_valid), .last_beat(last_beat)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int seq_col(int s, int k, int n);
    return s - (s % n) + ((s % n + k) % n);
  endfunction

  // issue a start at a negedge; on return, beat 0 is on the outputs
  task automatic kick(input logic [2:0] code, input logic ilv, input logic [7:0] sc);
    len_code = code; wrap_ilv = ilv; start_col = sc; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic t_reset;
    check("R1 valid", beat_valid, 0);
    check("R1 last", last_beat, 0);
    check("R1 col", col, 0);
  endtask

  task automatic t_fixed(input logic [2:0] code, input logic ilv, input logic [7:0] sc,
                         input int n, input string req);
    kick(code, ilv, sc);
    check("R2 first col", col, sc);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      check({req, " col"}, col, ilv ? (sc ^ k) : seq_col(sc, k, n));
      check("R6 valid", beat_valid, 1);
      check("R6 last", last_beat, (k == n-1) ? 1 : 0);
    end
    @(negedge clk);
    check("R6 ends", beat_valid, 0);
  endtask

  task automatic t_page;
    kick(3'b111, 0, 8'hF0);
    for (int k = 0; k < 300; k++) begin
      if (k > 0) @(negedge clk);
      check("R5 col", col, (8'hF0 + k) % 256);
      check("R5 last", last_beat, 0);
    end
    stop = 1;
    @(negedge clk);
    stop = 0;
    check("R5 stop", beat_valid, 0);
  endtask

  task automatic t_stop;
    kick(3'b011, 0, 8'h20);
    @(negedge clk);
    check("R7 beat1", col, 8'h21);
    stop = 1;
    @(negedge clk);
    stop = 0;
    check("R7 stopped", beat_valid, 0);
    // start and stop together: start wins
    len_code = 3'b010; wrap_ilv = 0; start_col = 8'h33; start = 1; stop = 1;
    @(negedge clk);
    start = 0; stop = 0;
    check("R7 start wins valid", beat_valid, 1);
    check("R7 start wins col", col, 8'h33);
    @(negedge clk);
    check("R7 continues", col, 8'h30);
    @(negedge clk); @(negedge clk);
    check("R7 last", last_beat, 1);
    @(negedge clk);
  endtask

  task automatic t_interrupt;
    kick(3'b011, 0, 8'h10);
    @(negedge clk);
    check("R8 old beat", col, 8'h11);
    kick(3'b010, 1, 8'h47);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      check("R8 new col", col, 8'h47 ^ k);
      check("R8 last", last_beat, (k == 3) ? 1 : 0);
    end
    @(negedge clk);
    check("R8 ends", beat_valid, 0);
  endtask

  task automatic t_b2b;
    len_code = 3'b011; wrap_ilv = 0; start = 1;
    for (int k = 0; k < 5; k++) begin
      start_col = 8'(8'h80 + 3*k);
      @(negedge clk);
      check("R10 col", col, 8'h80 + 3*k);
      check("R10 valid", beat_valid, 1);
    end
    start = 0;
    @(negedge clk);
    check("R10 follows", col, 8'h8D);
    stop = 1;
    @(negedge clk);
    stop = 0;
  endtask

  task automatic t_reserved;
    t_fixed(3'b100, 0, 8'h55, 1, "R9 code100");
    t_fixed(3'b101, 1, 8'h56, 1, "R9 code101");
    t_fixed(3'b110, 0, 8'h57, 1, "R9 code110");
    t_fixed(3'b111, 1, 8'h58, 1, "R9 ilv page");
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fixed(3'b000, 0, 8'h9B, 1, "R9 len1");
    t_fixed(3'b001, 0, 8'h9B, 2, "R3 seq2");
    t_fixed(3'b010, 0, 8'h9A, 4, "R3 seq4");
    t_fixed(3'b011, 0, 8'h3D, 8, "R3 seq8");
    t_fixed(3'b011, 0, 8'hFE, 8, "R3 seq8 top");
    t_fixed(3'b001, 1, 8'h9B, 2, "R4 ilv2");
    t_fixed(3'b010, 1, 8'h9A, 4, "R4 ilv4");
    t_fixed(3'b011, 1, 8'h3D, 8, "R4 ilv8");
    t_page;
    t_stop;
    t_interrupt;
    t_b2b;
    t_reserved;
    done = 1;
    report;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report;
    end
  end
endmodule